// File: doc/BRIEF.md
# Inter-Processor Interrupt Command Register

Each processor owns one of these command registers and uses it to send interrupt messages to other processors. Software first writes the upper 32-bit word, which holds the target processor's identifier. It then writes the lower 32-bit word, which holds the vector, the delivery mode, a level flag and a shorthand code. Writing the lower word launches one message and has no other side effect.

At launch the block turns the shorthand code into an N-bit target mask. It does this using the stored destination, its own static identifier and a processor count set by a parameter. It then holds the message on a valid/ready output until the transport accepts it. For the whole time a message is outstanding, a busy bit in the lower word reads as one, and any new lower-word write is dropped.

Top module: `ipi_cmd_reg`

## Requirements
- R1: After reset, no message is offered, the busy bit reads 0 and both words read back as zero.
- R2: A write to the upper word (`wr_sel`=1) stores bits 31:24 as the destination. That word reads back with bits 23:0 as zero. The write sends no message and can be made while busy.
- R3: A lower-word write (`wr_sel`=0) made while idle stores the word and raises `msg_valid` on the next clock edge. It launches exactly one message.
- R4: The message carries the vector from bits 7:0, the delivery mode from bits 10:8 (000 fixed, 101 init, 110 startup) and the level flag from bit 14. Words 0x4500 and 0x4600 plus a page give init and startup with the level set, and a startup carries the page number in the vector.
- R5: With shorthand bits 19:18 = 00, the target mask has only the bit indexed by the stored destination set. It is all zero when that destination is N_CPU or higher.
- R6: With shorthand 01, the mask has only the sender's own bit set.
- R7: With shorthand 10, every mask bit is set.
- R8: With shorthand 11, every bit except the sender's is set, and the destination field has no effect.
- R9: Bit 12 of the lower word reads 1 from the launch edge until the edge where `msg_valid` and `msg_ready` are both high. The value written into bit 12 is discarded.
- R10: A lower-word write while busy is ignored. It changes neither the stored word nor the outstanding message, and it adds no second message.
- R11: While `msg_valid` is high and `msg_ready` is low, `msg_valid` and every message field stay unchanged.
- R12: An upper-word write while busy updates the destination but leaves the outstanding message unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| self_id | input | 8 | Static identifier of this processor |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Word select: 0 lower, 1 upper |
| wr_data | input | 32 | Write data |
| rd_sel | input | 1 | Read word select: 0 lower, 1 upper |
| rd_data | output | 32 | Read data of the selected word |
| msg_valid | output | 1 | Message offered |
| msg_ready | input | 1 | Transport accepts the message |
| msg_vector | output | 8 | Vector or startup page |
| msg_mode | output | 3 | Delivery mode |
| msg_level | output | 1 | Level-assert flag |
| msg_targets | output | N_CPU | One bit per target processor |

## Verification
If the busy state is wrong, it shows on the port the cycle after the launch or handshake edge. It appears either as a bit 12 that disagrees with `msg_valid`, or as a second message accepted in place of an ignored write. If the shorthand decode is wrong, the target mask is wrong on the very first cycle `msg_valid` is high. A corrupted stored word shows on the next read of that word. Because outputs are compared against the reference model on every clock, each such fault is reported within one cycle of becoming visible.

// File: rtl/ipi_pkg.sv
package ipi_pkg;
  localparam int WORD_W     = 32;
  localparam int DEST_W     = 8;
  localparam int VEC_W      = 8;
  localparam int MODE_W     = 3;
  localparam int VEC_LSB    = 0;
  localparam int MODE_LSB   = 8;
  localparam int BUSY_BIT   = 12;
  localparam int LEVEL_BIT  = 14;
  localparam int SH_LSB     = 18;
  localparam int DEST_LSB   = 24;

  typedef enum logic [1:0] {
    SH_DEST   = 2'b00,
    SH_SELF   = 2'b01,
    SH_ALL    = 2'b10,
    SH_OTHERS = 2'b11
  } shorthand_e;
endpackage

// File: rtl/ipi_target_decode.sv
module ipi_target_decode
  import ipi_pkg::*;
#(
  parameter int N_CPU = 8
) (
  input  shorthand_e         shorthand,
  input  logic [DEST_W-1:0]  dest_id,
  input  logic [DEST_W-1:0]  self_id,
  output logic [N_CPU-1:0]   targets
);
  logic [N_CPU-1:0] dest_hit;
  logic [N_CPU-1:0] self_hit;

  for (genvar i = 0; i < N_CPU; i++) begin : g_bit
    assign dest_hit[i] = (dest_id == DEST_W'(i));
    assign self_hit[i] = (self_id == DEST_W'(i));
  end

  always_comb begin
    unique case (shorthand)
      SH_DEST:   targets = dest_hit;
      SH_SELF:   targets = self_hit;
      SH_ALL:    targets = '1;
      default:   targets = ~self_hit;
    endcase
  end

  // Decode sanity next to the logic it guards
  always_comb begin
    if (shorthand == SH_SELF && 32'(self_id) < N_CPU)
      a_r6_self_onehot: assert ($onehot(targets));
    if (shorthand == SH_ALL)
      a_r7_all_set: assert (&targets);
    if (shorthand == SH_OTHERS && 32'(self_id) < N_CPU)
      a_r8_others_count: assert ($countones(targets) == N_CPU - 1);
    if (shorthand == SH_DEST && 32'(dest_id) >= N_CPU)
      a_r5_out_of_range: assert (targets == '0);
  end
endmodule

// File: rtl/ipi_cmd_store.sv
module ipi_cmd_store
  import ipi_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hi_we,
  input  logic              lo_we,
  input  logic [WORD_W-1:0] wr_data,
  output logic [DEST_W-1:0] dest_q,
  output logic [WORD_W-1:0] lo_q
);
  logic [DEST_W-1:0] dest_d;
  logic [WORD_W-1:0] lo_d;

  always_comb begin
    dest_d = dest_q;
    lo_d   = lo_q;
    if (hi_we) dest_d = wr_data[DEST_LSB +: DEST_W];
    if (lo_we) begin
      lo_d           = wr_data;
      lo_d[BUSY_BIT] = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dest_q <= '0;
      lo_q   <= '0;
    end else begin
      if (hi_we) dest_q <= dest_d;
      if (lo_we) lo_q   <= lo_d;
    end
  end
endmodule

// File: rtl/ipi_msg_out.sv
module ipi_msg_out
  import ipi_pkg::*;
#(
  parameter int N_CPU = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             launch,
  input  logic [VEC_W-1:0] vec_in,
  input  logic [MODE_W-1:0] mode_in,
  input  logic             level_in,
  input  logic [N_CPU-1:0] tgt_in,
  input  logic             ready,
  output logic             valid,
  output logic [VEC_W-1:0] vec_q,
  output logic [MODE_W-1:0] mode_q,
  output logic             level_q,
  output logic [N_CPU-1:0] tgt_q
);
  logic valid_d;
  logic load;

  assign load = launch && !valid;

  always_comb begin
    valid_d = valid;
    if (valid && ready) valid_d = 1'b0;
    if (load)           valid_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid <= 1'b0;
    else        valid <= valid_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vec_q   <= '0;
      mode_q  <= '0;
      level_q <= 1'b0;
      tgt_q   <= '0;
    end else if (load) begin
      vec_q   <= vec_in;
      mode_q  <= mode_in;
      level_q <= level_in;
      tgt_q   <= tgt_in;
    end
  end

  a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
    valid && !ready |=> valid && $stable(vec_q) && $stable(mode_q)
                        && $stable(level_q) && $stable(tgt_q));
  a_r9_release: assert property (@(posedge clk) disable iff (!rst_n)
    valid && ready && !launch |=> !valid);
endmodule

// File: rtl/ipi_cmd_reg.sv
module ipi_cmd_reg
  import ipi_pkg::*;
#(
  parameter int N_CPU = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [7:0]        self_id,
  input  logic              wr_en,
  input  logic              wr_sel,
  input  logic [31:0]       wr_data,
  input  logic              rd_sel,
  output logic [31:0]       rd_data,
  output logic              msg_valid,
  input  logic              msg_ready,
  output logic [7:0]        msg_vector,
  output logic [2:0]        msg_mode,
  output logic              msg_level,
  output logic [N_CPU-1:0]  msg_targets
);
  logic              busy;
  logic              hi_we;
  logic              lo_we;
  logic [DEST_W-1:0] dest_q;
  logic [WORD_W-1:0] lo_q;
  logic [N_CPU-1:0]  tgt_next;
  shorthand_e        sh_in;

  assign busy  = msg_valid;
  assign hi_we = wr_en && wr_sel;
  assign lo_we = wr_en && !wr_sel && !busy;
  assign sh_in = shorthand_e'(wr_data[SH_LSB +: 2]);

  ipi_cmd_store u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .hi_we   (hi_we),
    .lo_we   (lo_we),
    .wr_data (wr_data),
    .dest_q  (dest_q),
    .lo_q    (lo_q)
  );

  ipi_target_decode #(.N_CPU(N_CPU)) u_decode (
    .shorthand (sh_in),
    .dest_id   (dest_q),
    .self_id   (self_id),
    .targets   (tgt_next)
  );

  ipi_msg_out #(.N_CPU(N_CPU)) u_out (
    .clk      (clk),
    .rst_n    (rst_n),
    .launch   (lo_we),
    .vec_in   (wr_data[VEC_LSB +: VEC_W]),
    .mode_in  (wr_data[MODE_LSB +: MODE_W]),
    .level_in (wr_data[LEVEL_BIT]),
    .tgt_in   (tgt_next),
    .ready    (msg_ready),
    .valid    (msg_valid),
    .vec_q    (msg_vector),
    .mode_q   (msg_mode),
    .level_q  (msg_level),
    .tgt_q    (msg_targets)
  );

  always_comb begin
    if (rd_sel) begin
      rd_data = '0;
      rd_data[DEST_LSB +: DEST_W] = dest_q;
    end else begin
      rd_data = lo_q;
      rd_data[BUSY_BIT] = busy;
    end
  end

  a_r3_launch_source: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(msg_valid) |-> $past(wr_en && !wr_sel));
  a_r2_high_no_send: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_sel && !msg_valid |=> !msg_valid);
  a_r10_busy_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && !wr_sel && msg_valid |=> $stable(lo_q));
  a_r12_high_keeps_msg: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_sel && msg_valid && !msg_ready |=> $stable(msg_targets));
endmodule

// File: tb/ipi_cmd_reg_tb.sv
module ipi_cmd_reg_tb;
  localparam int N = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  self_id = 8'd2;
  logic        wr_en = 1'b0;
  logic        wr_sel = 1'b0;
  logic [31:0] wr_data = '0;
  logic        rd_sel = 1'b0;
  logic [31:0] rd_data;
  logic        msg_valid;
  logic        msg_ready = 1'b0;
  logic [7:0]  msg_vector;
  logic [2:0]  msg_mode;
  logic        msg_level;
  logic [N-1:0] msg_targets;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  string tag = "R1";

  always #5 clk = ~clk;

  ipi_cmd_reg #(.N_CPU(N)) u_dut (
    .clk(clk), .rst_n(rst_n), .self_id(self_id), .wr_en(wr_en),
    .wr_sel(wr_sel), .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data),
    .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_vector(msg_vector),
    .msg_mode(msg_mode), .msg_level(msg_level), .msg_targets(msg_targets)
  );

  // Behavioural reference model
  logic [7:0]   m_dest;
  logic [31:0]  m_lo;
  logic         m_valid;
  logic [7:0]   m_vec;
  logic [2:0]   m_mode;
  logic         m_level;
  logic [N-1:0] m_tgt;

  function automatic logic [N-1:0] want_targets(input logic [1:0] sh,
                                                input int dest, input int me);
    logic [N-1:0] r;
    for (int i = 0; i < N; i++) begin
      case (sh)
        2'd0: r[i] = (i == dest);
        2'd1: r[i] = (i == me);
        2'd2: r[i] = 1'b1;
        default: r[i] = (i != me);
      endcase
    end
    return r;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_dest <= '0; m_lo <= '0; m_valid <= 1'b0;
      m_vec <= '0; m_mode <= '0; m_level <= 1'b0; m_tgt <= '0;
    end else begin
      if (m_valid && msg_ready) m_valid <= 1'b0;
      if (wr_en && wr_sel) m_dest <= wr_data[31:24];
      if (wr_en && !wr_sel && !m_valid) begin
        m_lo    <= wr_data & ~32'h1000;
        m_valid <= 1'b1;
        m_vec   <= wr_data[7:0];
        m_mode  <= wr_data[10:8];
        m_level <= wr_data[14];
        m_tgt   <= want_targets(wr_data[19:18], int'(m_dest), int'(self_id));
      end
    end
  end

  always @(posedge clk) rd_sel <= ~rd_sel;

  task automatic chk(input string t, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h t=%0t", t, act, exp, $time);
    end
  endtask

  // Per-clock comparison against the model
  always @(negedge clk) begin
    if (rst_n) begin
      chk({tag, " valid"}, 64'(msg_valid), 64'(m_valid));
      chk({tag, " read"}, 64'(rd_data),
          rd_sel ? 64'({m_dest, 24'h0}) : 64'(m_lo | (32'(m_valid) << 12)));
      if (m_valid)
        chk({tag, " payload"}, 64'({msg_vector, msg_mode, msg_level, msg_targets}),
            64'({m_vec, m_mode, m_level, m_tgt}));
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic wr(input logic sel, input logic [31:0] d);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic drain();
    msg_ready = 1'b1;
    @(negedge clk);
    msg_ready = 1'b0;
    @(negedge clk);
  endtask

  task automatic send(input string t, input logic [7:0] dest, input logic [31:0] lo,
                      input logic [N-1:0] exp_tgt);
    tag = t;
    wr(1'b1, {dest, 24'h0});
    wr(1'b0, lo);
    chk({t, " launched"}, 64'(msg_valid), 64'd1);
    chk({t, " targets"}, 64'(msg_targets), 64'(exp_tgt));
    drain();
  endtask

  initial begin
    @(negedge clk); @(negedge clk);
    // R1 reset state
    chk("R1 valid", 64'(msg_valid), 64'd0);
    chk("R1 read", 64'(rd_data), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 high word only: nothing sent
    tag = "R2";
    wr(1'b1, 32'h03AB_CDEF);
    repeat (2) @(negedge clk);
    chk("R2 no message", 64'(msg_valid), 64'd0);

    // R3/R11/R9/R10/R12 fixed message held without ready
    tag = "R3";
    wr(1'b0, 32'h0000_0030);
    chk("R3 launch", 64'(msg_valid), 64'd1);
    chk("R5 dest mask", 64'(msg_targets), 64'h08);
    tag = "R11";
    repeat (3) @(negedge clk);
    chk("R11 held", 64'({msg_valid, msg_vector}), 64'({1'b1, 8'h30}));
    tag = "R10";
    wr(1'b0, 32'h000C_0077);
    chk("R10 vector kept", 64'(msg_vector), 64'h30);
    tag = "R12";
    wr(1'b1, 32'h0600_0000);
    chk("R12 targets kept", 64'(msg_targets), 64'h08);
    tag = "R9";
    drain();
    chk("R9 idle after handshake", 64'(msg_valid), 64'd0);

    // R4 init and startup encodings
    send("R4 init", 8'd5, 32'h0000_4500, 8'h20);
    chk("R4 init mode", 64'({msg_mode, msg_level}), 64'({3'd5, 1'b1}));
    send("R4 startup", 8'd1, 32'h0000_4608, 8'h02);
    chk("R4 startup page", 64'({msg_vector, msg_mode, msg_level}), 64'({8'h08, 3'd6, 1'b1}));

    // R6 R7 R8 R5 shorthands
    send("R6 self", 8'd7, 32'h0004_0031, 8'h04);
    send("R7 all", 8'd7, 32'h0008_0032, 8'hFF);
    send("R8 others", 8'd2, 32'h000C_0033, 8'hFB);
    send("R8 others dest ignored", 8'd6, 32'h000C_0034, 8'hFB);
    send("R5 out of range", 8'd9, 32'h0000_0035, 8'h00);

    // R9 written busy bit discarded
    tag = "R9";
    wr(1'b0, 32'h0000_1040);
    msg_ready = 1'b1;
    @(negedge clk);
    msg_ready = 1'b0;
    rd_sel = 1'b0;
    #1;
    chk("R9 bit12 clear", 64'(rd_data[12]), 64'd0);
    repeat (3) @(negedge clk);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule